// File: doc/BRIEF.md
# Masked Limit Interrupt Aggregator

This block sits behind a round-robin measurement sequencer. Each finished measurement arrives as one beat carrying a channel index, the measured value and that channel's high and low limits. A reading above the high limit or below the low limit is an error event. Error events, plus three external event pins, are recorded in two sticky 8-bit status registers. The status registers are combined with two mask registers to drive a single interrupt pin, whose enable and active level are programmable. The block also keeps the latest reading of every channel, which can be read back through a select port.

Software reads a status register by pulsing its read strobe. The value shown on the status output is the value returned. The register clears on that edge, which releases the interrupt unless another unmasked bit is still set. A clear bit in the control register holds the interrupt pin inactive without touching status, and it stops the measurement loop. The control register comes out of reset with that clear bit set, so the monitor stays idle until software writes it. The result input is a valid/ready stream with `res_ready` equal to `mon_run`. When monitoring is halted, the sequencer is back-pressured and must hold its beat until ready returns. A beat transfers only on a clock edge where both valid and ready are high.

Top module: `lim_agg`

## Requirements
- R1: An accepted result sets its status bit when the value is strictly greater than the high limit or strictly less than the low limit. A value equal to either limit sets nothing.
- R2: Channels 0 to 6 map to `sr1` bits 0 to 6. Channel 7 (hot temperature) maps to `sr2` bit 0, channel 8 (fan 1) to bit 2, channel 9 (fan 2) to bit 3, and channel 10 (overtemperature) to bit 5. `sr2` bits 6 and 7 always read 0.
- R3: The external pins pass through a SYNC_STAGES-flop synchronizer and are recorded only while `mon_run` is high. A low level on `ext_int_n` sets `sr1` bit 7. A low level on `bti_n` sets `sr2` bit 1. A rising edge on `gpi` sets `sr2` bit 4, and a level that stays high does not set it again.
- R4: A status bit whose mask bit is 1 is still recorded but does not make the interrupt active. Mask bit k of `mask1`/`mask2` covers status bit k of `sr1`/`sr2`.
- R5: Status bits are sticky. A read strobe clears its register on that clock edge. An event arriving on the same edge is kept, so the register then holds only that event.
- R6: Control bit 3 (clear) forces the interrupt inactive, leaves the status untouched and drives `mon_run` and `res_ready` low, so no result is accepted.
- R7: The interrupt is active when control bit 1 (enable) is 1, clear is 0 and an unmasked status bit is set. Control bit 2 selects the active level of `int_pin`: 1 means active-high, 0 means active-low.
- R8: A channel whose `chan_dis` bit is 1 raises no event, and its stored reading is written as 0. While that bit is set, `rd_data` for the channel reads 0.
- R9: After reset the control register holds 08h, both status registers hold 0, `mon_run` is 0 and `int_pin` is 1. Control bit 0 (start) together with clear equal to 0 gives `mon_run`.
- R10: `res_ready` equals `mon_run`. A beat whose channel index is 11 or above is accepted but changes neither status nor readings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat accepted when high |
| res_chan | input | 4 | Channel index of the beat |
| res_value | input | VAL_W | Measured value |
| res_hi | input | VAL_W | High limit |
| res_lo | input | VAL_W | Low limit |
| ext_int_n | input | 1 | External interrupt, active low |
| bti_n | input | 1 | Board temperature event, active low |
| gpi | input | 1 | General input / chassis event, rising edge |
| chan_dis | input | 11 | Per-channel disable |
| mask1 | input | 8 | Mask for sr1 |
| mask2 | input | 8 | Mask for sr2 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_q | output | 8 | Control register contents |
| sr1_rd | input | 1 | Read-and-clear strobe for sr1 |
| sr2_rd | input | 1 | Read-and-clear strobe for sr2 |
| sr1 | output | 8 | Status register 1 |
| sr2 | output | 8 | Status register 2 |
| rd_sel | input | 4 | Channel select for reading readback |
| rd_data | output | VAL_W | Stored reading of the selected channel |
| int_pin | output | 1 | Interrupt pin level |
| mon_run | output | 1 | Monitoring loop enable |

## Verification
The assertions assume that the sequencer holds `res_valid` and its beat stable only through the handshake. They also assume that the event pins are free to change at any time, and that software never pulses a read strobe except as a single-cycle pulse. The bench changes every input on the falling edge. It holds each pulse for exactly one rising edge and holds external pin levels for several cycles, so that the synchronizer latency is covered before a status value is checked.

// File: rtl/lim_agg_pkg.sv
package lim_agg_pkg;
  localparam int NUM_CH = 11;
  localparam int CHAN_W = 4;
  localparam int SR_W   = 8;

  localparam int CTL_START = 0;
  localparam int CTL_INTEN = 1;
  localparam int CTL_POL   = 2;
  localparam int CTL_CLR   = 3;
  localparam logic [SR_W-1:0] CTL_RST = 8'h08;

  localparam int SR1_EXT = 7;
  localparam int SR2_BTI = 1;
  localparam int SR2_GPI = 4;
  localparam logic [SR_W-1:0] SR2_LIVE = 8'h3F;

  typedef struct packed {
    logic       grp;
    logic [2:0] pos;
  } slot_t;

  function automatic slot_t chan_slot(input int ch);
    slot_t s;
    s.grp = 1'b1;
    case (ch)
      7:       s.pos = 3'd0;
      8:       s.pos = 3'd2;
      9:       s.pos = 3'd3;
      10:      s.pos = 3'd5;
      default: begin s.grp = 1'b0; s.pos = 3'(ch); end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lim_event_decode.sv
module lim_event_decode
  import lim_agg_pkg::*;
#(
  parameter int VAL_W = 10
) (
  input  logic              acc,
  input  logic [CHAN_W-1:0] chan,
  input  logic [VAL_W-1:0]  value,
  input  logic [VAL_W-1:0]  hi,
  input  logic [VAL_W-1:0]  lo,
  input  logic [NUM_CH-1:0] dis,
  output logic [NUM_CH-1:0] hit,
  output logic [SR_W-1:0]   set1,
  output logic [SR_W-1:0]   set2
);
  logic viol;
  assign viol = (value > hi) || (value < lo);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit[g] = acc && (chan == CHAN_W'(g));
  end

  always_comb begin
    set1 = '0;
    set2 = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i] && viol && !dis[i]) begin
        if (chan_slot(i).grp) set2[chan_slot(i).pos] = 1'b1;
        else                  set1[chan_slot(i).pos] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_event_sync.sv
module ext_event_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_int_n,
  input  logic bti_n,
  input  logic gpi,
  output logic ev_ext,
  output logic ev_bti,
  output logic ev_gpi
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE = 3'b011;

  logic [NPIN-1:0] raw;
  logic [NPIN-1:0] synced;
  logic            gpi_prev;

  assign raw = {gpi, bti_n, ext_int_n};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE[p]}};
      else        chain <= {chain[STAGES-2:0], raw[p]};
    end
    assign synced[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpi_prev <= 1'b0;
    else        gpi_prev <= synced[2];
  end

  assign ev_ext = run && !synced[0];
  assign ev_bti = run && !synced[1];
  assign ev_gpi = run && synced[2] && !gpi_prev;
endmodule

// File: rtl/status_bank.sv
module status_bank
  import lim_agg_pkg::*;
#(
  parameter logic [SR_W-1:0] LIVE = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SR_W-1:0] set,
  input  logic            rd,
  output logic [SR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ((rd ? '0 : q) | set) & LIVE;
  end
endmodule

// File: rtl/int_drive.sv
module int_drive
  import lim_agg_pkg::*;
(
  input  logic [SR_W-1:0] sr1,
  input  logic [SR_W-1:0] sr2,
  input  logic [SR_W-1:0] mask1,
  input  logic [SR_W-1:0] mask2,
  input  logic [SR_W-1:0] ctl,
  output logic            pin
);
  logic pending, active;
  assign pending = |(sr1 & ~mask1) || |(sr2 & ~mask2 & SR2_LIVE);
  assign active  = ctl[CTL_INTEN] && !ctl[CTL_CLR] && pending;
  assign pin     = ctl[CTL_POL] ? active : !active;
endmodule

// File: rtl/lim_agg.sv
module lim_agg
  import lim_agg_pkg::*;
#(
  parameter int VAL_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [VAL_W-1:0]  res_value,
  input  logic [VAL_W-1:0]  res_hi,
  input  logic [VAL_W-1:0]  res_lo,
  input  logic              ext_int_n,
  input  logic              bti_n,
  input  logic              gpi,
  input  logic [NUM_CH-1:0] chan_dis,
  input  logic [SR_W-1:0]   mask1,
  input  logic [SR_W-1:0]   mask2,
  input  logic              ctl_we,
  input  logic [SR_W-1:0]   ctl_wdata,
  output logic [SR_W-1:0]   ctl_q,
  input  logic              sr1_rd,
  input  logic              sr2_rd,
  output logic [SR_W-1:0]   sr1,
  output logic [SR_W-1:0]   sr2,
  input  logic [CHAN_W-1:0] rd_sel,
  output logic [VAL_W-1:0]  rd_data,
  output logic              int_pin,
  output logic              mon_run
);
  logic              acc;
  logic [NUM_CH-1:0] hit;
  logic [SR_W-1:0]   res_set1, res_set2, ev1, ev2;
  logic              ev_ext, ev_bti, ev_gpi;
  logic [VAL_W-1:0]  store [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign mon_run   = ctl_q[CTL_START] && !ctl_q[CTL_CLR];
  assign res_ready = mon_run;
  assign acc       = res_valid && res_ready;

  lim_event_decode #(.VAL_W(VAL_W)) u_dec (
    .acc(acc), .chan(res_chan), .value(res_value), .hi(res_hi), .lo(res_lo),
    .dis(chan_dis), .hit(hit), .set1(res_set1), .set2(res_set2)
  );

  ext_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(mon_run),
    .ext_int_n(ext_int_n), .bti_n(bti_n), .gpi(gpi),
    .ev_ext(ev_ext), .ev_bti(ev_bti), .ev_gpi(ev_gpi)
  );

  always_comb begin
    ev1 = res_set1;
    ev2 = res_set2;
    ev1[SR1_EXT] = ev1[SR1_EXT] | ev_ext;
    ev2[SR2_BTI] = ev2[SR2_BTI] | ev_bti;
    ev2[SR2_GPI] = ev2[SR2_GPI] | ev_gpi;
  end

  status_bank #(.LIVE('1)) u_sr1 (
    .clk(clk), .rst_n(rst_n), .set(ev1), .rd(sr1_rd), .q(sr1)
  );
  status_bank #(.LIVE(SR2_LIVE)) u_sr2 (
    .clk(clk), .rst_n(rst_n), .set(ev2), .rd(sr2_rd), .q(sr2)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      store[c] <= '0;
      else if (hit[c]) store[c] <= chan_dis[c] ? '0 : res_value;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NUM_CH && !chan_dis[rd_sel]) rd_data = store[rd_sel];
  end

  int_drive u_int (
    .sr1(sr1), .sr2(sr2), .mask1(mask1), .mask2(mask2), .ctl(ctl_q), .pin(int_pin)
  );
endmodule

// File: rtl/lim_agg_chk.sv
module lim_agg_chk
  import lim_agg_pkg::*;
#(
  parameter int VAL_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SR_W-1:0]   ctl_q,
  input logic [SR_W-1:0]   sr1,
  input logic [SR_W-1:0]   sr2,
  input logic [SR_W-1:0]   mask1,
  input logic [SR_W-1:0]   mask2,
  input logic [SR_W-1:0]   ev1,
  input logic              sr1_rd,
  input logic              int_pin,
  input logic              mon_run,
  input logic [NUM_CH-1:0] chan_dis,
  input logic [CHAN_W-1:0] rd_sel,
  input logic [VAL_W-1:0]  rd_data
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr2[7:6] == 2'b00); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sr1 & ~mask1) == '0 && (sr2 & ~mask2) == '0) |-> int_pin == !ctl_q[CTL_POL]); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sr1_rd |=> (sr1 & $past(sr1)) == $past(sr1)); // R5
  AST_RD_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    sr1_rd |=> sr1 == $past(ev1)); // R5
  AST_CLR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_CLR] |-> (!mon_run && int_pin == !ctl_q[CTL_POL])); // R6
  AST_DIS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_sel) < NUM_CH && chan_dis[rd_sel]) |-> rd_data == '0); // R8
endmodule

bind lim_agg lim_agg_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sr1(sr1), .sr2(sr2),
  .mask1(mask1), .mask2(mask2), .ev1(ev1), .sr1_rd(sr1_rd),
  .int_pin(int_pin), .mon_run(mon_run), .chan_dis(chan_dis),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/lim_agg_test.sv
module lim_agg_test;
  logic clk = 0, rst_n = 0;
  logic res_valid = 0, res_ready;
  logic [3:0] res_chan = 0;
  logic [9:0] res_value = 0, res_hi = 0, res_lo = 0;
  logic ext_int_n = 1, bti_n = 1, gpi = 0;
  logic [10:0] chan_dis = 0;
  logic [7:0] mask1 = 0, mask2 = 0, ctl_wdata = 0, ctl_q, sr1, sr2;
  logic ctl_we = 0, sr1_rd = 0, sr2_rd = 0, int_pin, mon_run;
  logic [3:0] rd_sel = 0;
  logic [9:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lim_agg uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(int ch, int v, int hi, int lo);
    res_chan = 4'(ch); res_value = 10'(v); res_hi = 10'(hi); res_lo = 10'(lo);
    res_valid = 1;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_we = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic rd_both();
    sr1_rd = 1; sr2_rd = 1;
    @(negedge clk);
    sr1_rd = 0; sr2_rd = 0;
  endtask

  task automatic t_reset();
    chk("R9 ctl", ctl_q, 8'h08);
    chk("R9 sr1", sr1, 0);
    chk("R9 sr2", sr2, 0);
    chk("R9 run", mon_run, 0);
    chk("R9 int", int_pin, 1);
    chk("R10 ready idle", res_ready, 0);
    wr_ctl(8'h03);
    chk("R9 run on", mon_run, 1);
    chk("R10 ready", res_ready, 1);
  endtask

  task automatic t_window();
    send(2, 100, 200, 50);
    chk("R1 inside", sr1, 0);
    send(2, 200, 200, 50);
    chk("R1 equal hi", sr1, 0);
    send(2, 50, 200, 50);
    chk("R1 equal lo", sr1, 0);
    send(2, 201, 200, 50);
    chk("R1 above", sr1, 8'h04);
    chk("R7 active low", int_pin, 0);
    rd_both();
    send(6, 49, 200, 50);
    chk("R1 below", sr1, 8'h40);
    rd_both();
    chk("R5 read clears", sr1, 0);
    chk("R5 int released", int_pin, 1);
  endtask

  task automatic t_map();
    send(7, 5, 100, 10);
    chk("R2 hot", sr2, 8'h01);
    send(8, 300, 200, 0);
    chk("R2 fan1", sr2, 8'h05);
    send(9, 300, 200, 0);
    chk("R2 fan2", sr2, 8'h0D);
    send(10, 300, 200, 0);
    chk("R2 ovt", sr2, 8'h2D);
    chk("R2 sr1 untouched", sr1, 0);
    rd_both();
    send(12, 900, 10, 5);
    chk("R10 bad index sr1", sr1, 0);
    chk("R10 bad index sr2", sr2, 0);
  endtask

  task automatic t_mask();
    mask1 = 8'h08;
    send(3, 900, 800, 0);
    chk("R4 recorded", sr1, 8'h08);
    chk("R4 masked", int_pin, 1);
    mask1 = 0;
    #1 chk("R4 unmasked", int_pin, 0);
    @(negedge clk);
    rd_both();
  endtask

  task automatic t_pol();
    send(0, 900, 800, 0);
    wr_ctl(8'h07);
    chk("R7 active high", int_pin, 1);
    wr_ctl(8'h05);
    chk("R7 disabled", int_pin, 0);
    wr_ctl(8'h03);
    chk("R7 back low", int_pin, 0);
  endtask

  task automatic t_clear();
    wr_ctl(8'h0B);
    chk("R6 int off", int_pin, 1);
    chk("R6 status kept", sr1, 8'h01);
    chk("R6 run off", mon_run, 0);
    chk("R6 ready off", res_ready, 0);
    send(1, 900, 800, 0);
    chk("R6 no accept", sr1, 8'h01);
    wr_ctl(8'h03);
    chk("R6 int back", int_pin, 0);
    rd_both();
  endtask

  task automatic t_race();
    send(2, 900, 800, 0);
    sr1_rd = 1;
    send(5, 900, 800, 0);
    sr1_rd = 0;
    chk("R5 race keeps new", sr1, 8'h20);
    rd_both();
  endtask

  task automatic t_dis();
    chan_dis = 11'h010; rd_sel = 4;
    send(4, 900, 800, 0);
    chk("R8 no event", sr1, 0);
    chk("R8 reads zero", rd_data, 0);
    chan_dis = 0;
    #1 chk("R8 stored zero", rd_data, 0);
    @(negedge clk);
    send(4, 300, 400, 0);
    chk("R8 reading", rd_data, 300);
    chan_dis = 11'h010;
    #1 chk("R8 masked read", rd_data, 0);
    @(negedge clk);
    chan_dis = 0;
  endtask

  task automatic t_ext();
    ext_int_n = 0; repeat (4) @(negedge clk);
    ext_int_n = 1; repeat (4) @(negedge clk);
    chk("R3 ext low", sr1, 8'h80);
    rd_both();
    gpi = 1; repeat (4) @(negedge clk);
    chk("R3 gpi rise", sr2, 8'h10);
    rd_both();
    repeat (3) @(negedge clk);
    chk("R3 gpi level no reset", sr2, 0);
    gpi = 0;
    bti_n = 0; repeat (4) @(negedge clk);
    bti_n = 1; repeat (4) @(negedge clk);
    chk("R3 bti low", sr2, 8'h02);
    rd_both();
    wr_ctl(8'h0B);
    ext_int_n = 0; repeat (4) @(negedge clk);
    ext_int_n = 1; repeat (4) @(negedge clk);
    chk("R3 halted ignores", sr1, 0);
    wr_ctl(8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_map();
    t_mask();
    t_pol();
    t_clear();
    t_race();
    t_dis();
    t_ext();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule